// File: doc/BRIEF.md
# Parallel ADC Read Sequencer

This block is the host-side controller for a sampling converter with a parallel result bus. The converter is run through four lines: an active-low chip select, a read/convert strobe, a byte-select and a busy status. When the host raises a request while the sequencer is idle, the sequencer drops chip select and the strobe together to start a conversion. It then returns the strobe to high and releases chip select, so the converter cannot be retriggered when busy comes back. It waits for the rising edge of busy and re-selects the converter with the strobe high, which turns on the converter's data drivers.

The result is 16 bits wide. It is read either as one word or as two byte reads over the lower eight lanes of the bus. Each read waits a programmable number of clocks for bus access time before the bus is sampled. The finished result comes out with a single-cycle valid pulse. If busy does not rise within a programmable window, the sequencer gives up, pulses an error and goes back to idle. The strobe low width, the access wait and the busy window are set by inputs. Only one request is taken per conversion.

Top module: `adc_rd_seq`

## Requirements
- R1: After reset, `adc_cs_n`=1, `adc_rc`=1, `adc_byte`=0, `res_valid`=0, `tmo_err`=0 and `req_ready`=1.
- R2: A request taken in idle drives `adc_rc` low, with `adc_cs_n` also low, for exactly max(`cvt_clks`,1) consecutive clocks. After that `adc_rc` returns high.
- R3: Whenever `adc_busy` rises, `adc_cs_n` or `adc_rc` is already high. Each accepted request therefore starts exactly one conversion, where a start is a fall of (`adc_cs_n` OR `adc_rc`).
- R4: Once the strobe pulse ends, the sequencer watches for a rising edge of `adc_busy` for max(`tmo_clks`,1) clocks. If no rising edge comes in that window, `tmo_err` pulses for one clock, no result is issued, and the sequencer returns to idle with `adc_cs_n`=1.
- R5: The bus is sampled only while `adc_cs_n`=0 and `adc_rc`=1. Each read samples on the clock edge that comes `acc_clks` full clocks after the first cycle in which the read's select state is presented.
- R6: In word mode (`byte_mode`=0 at request), one read is made with `adc_byte`=0, and `res_data` equals the full 16-bit bus.
- R7: In byte mode (`byte_mode`=1 at request), two reads are made on `adc_data[7:0]`. The first uses `adc_byte`=0 and gives bits 7:0 of the result. The second uses `adc_byte`=1 and gives bits 15:8. Each read has its own access wait.
- R8: Each completed transaction gives exactly one `res_valid` pulse, one clock long, with the assembled result on `res_data`.
- R9: `adc_cs_n` is high in idle and during the busy wait. `req_ready` is high only in idle, and a request raised while `req_ready`=0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Conversion request, taken only when idle |
| byte_mode | input | 1 | 1 selects two byte reads, 0 selects one word read |
| cvt_clks | input | CW | Strobe low width in clocks (0 is treated as 1) |
| acc_clks | input | CW | Access wait before each sample, in clocks |
| tmo_clks | input | CW | Busy wait window in clocks (0 is treated as 1) |
| req_ready | output | 1 | High while idle |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rc | output | 1 | Read/convert strobe, low to convert, high to read |
| adc_byte | output | 1 | Byte select, 1 puts the high byte on the lower lanes |
| adc_busy | input | 1 | Converter busy, low while converting |
| adc_data | input | DW | Converter parallel result bus |
| res_data | output | DW | Assembled conversion result |
| res_valid | output | 1 | One-clock pulse with each result |
| tmo_err | output | 1 | One-clock pulse when busy does not rise in time |

## Verification
A converter model in the bench drives a poison pattern on the bus until the enable has been held for exactly the programmed access wait, so sampling one clock early is caught. In byte mode the model swaps the bus halves when byte-select is high, so an error in read order or byte assembly changes the word. Random words, strobe widths and conversion lengths are mixed with directed cases: a zero strobe setting, a zero busy window, and busy windows one clock short of and exactly at the conversion length. These last two separate timeout from success at the boundary. A second request raised in the middle of a transaction, together with a count of conversion starts, shows that busy requests are ignored and that the converter is never retriggered.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_CONV = 3'd1,
    S_WAIT = 3'd2,
    S_RDA  = 3'd3,
    S_RDB  = 3'd4
  } seq_state_t;

  // rising edge between a registered sample and the live level
  function automatic logic rising(input logic prev, input logic cur);
    return cur & ~prev;
  endfunction

endpackage

// File: rtl/seq_countdown.sv
module seq_countdown #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/seq_edge.sv
module seq_edge
  import adc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  // reset to 1 so a level already high after reset is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl;
  end

  assign rise = rising(lvl_q, lvl);
endmodule

// File: rtl/seq_assemble.sv
module seq_assemble #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_word,
  input  logic          cap_lo,
  input  logic          cap_hi,
  input  logic [DW-1:0] bus,
  output logic [DW-1:0] res_data,
  output logic          res_valid
);
  localparam int HW = DW / 2;

  logic [HW-1:0] lo_q;

  function automatic logic [DW-1:0] join_halves(input logic [HW-1:0] hi,
                                                input logic [HW-1:0] lo);
    return {hi, lo};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= '0;
      res_data  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= cap_word | cap_hi;
      if (cap_lo)   lo_q     <= bus[HW-1:0];
      if (cap_word) res_data <= bus;
      if (cap_hi)   res_data <= join_halves(bus[HW-1:0], lo_q);
    end
  end

  AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);                                       // R8
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          byte_mode,
  input  logic [CW-1:0] cvt_clks,
  input  logic [CW-1:0] acc_clks,
  input  logic [CW-1:0] tmo_clks,
  output logic          req_ready,
  output logic          adc_cs_n,
  output logic          adc_rc,
  output logic          adc_byte,
  input  logic          adc_busy,
  input  logic [DW-1:0] adc_data,
  output logic [DW-1:0] res_data,
  output logic          res_valid,
  output logic          tmo_err
);
  seq_state_t    state, state_nx;
  logic          mode_q;
  logic          cnt_load, cnt_zero, busy_rise;
  logic [CW-1:0] cnt_val;
  // named internal events
  logic          take_req, conv_done, tmo_hit, sample_fire;
  logic          cap_word, cap_lo, cap_hi;

  // a setting of 0 behaves as 1; the counter runs from N-1 down to 0
  function automatic logic [CW-1:0] reload_min1(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  seq_countdown #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  seq_edge u_busy (
    .clk(clk), .rst_n(rst_n), .lvl(adc_busy), .rise(busy_rise)
  );

  always_comb begin
    state_nx    = state;
    cnt_load    = 1'b0;
    cnt_val     = '0;
    take_req    = 1'b0;
    conv_done   = 1'b0;
    tmo_hit     = 1'b0;
    sample_fire = 1'b0;
    case (state)
      S_IDLE: if (req) begin
        take_req = 1'b1;
        state_nx = S_CONV;
        cnt_load = 1'b1;
        cnt_val  = reload_min1(cvt_clks);
      end
      S_CONV: if (cnt_zero) begin
        conv_done = 1'b1;
        state_nx  = S_WAIT;
        cnt_load  = 1'b1;
        cnt_val   = reload_min1(tmo_clks);
      end
      S_WAIT: begin
        if (busy_rise) begin
          state_nx = S_RDA;
          cnt_load = 1'b1;
          cnt_val  = acc_clks;
        end else if (cnt_zero) begin
          tmo_hit  = 1'b1;
          state_nx = S_IDLE;
        end
      end
      S_RDA: if (cnt_zero) begin
        sample_fire = 1'b1;
        if (mode_q) begin
          state_nx = S_RDB;
          cnt_load = 1'b1;
          cnt_val  = acc_clks;
        end else begin
          state_nx = S_IDLE;
        end
      end
      S_RDB: if (cnt_zero) begin
        sample_fire = 1'b1;
        state_nx    = S_IDLE;
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      mode_q  <= 1'b0;
      tmo_err <= 1'b0;
    end else begin
      state   <= state_nx;
      tmo_err <= tmo_hit;
      if (take_req) mode_q <= byte_mode;
    end
  end

  // pin decode: select during strobe and reads, strobe low only to convert
  always_comb begin
    adc_cs_n  = !((state == S_CONV) || (state == S_RDA) || (state == S_RDB));
    adc_rc    = (state != S_CONV);
    adc_byte  = (state == S_RDB);
    req_ready = (state == S_IDLE);
  end

  assign cap_word = sample_fire && (state == S_RDA) && !mode_q;
  assign cap_lo   = sample_fire && (state == S_RDA) &&  mode_q;
  assign cap_hi   = sample_fire && (state == S_RDB);

  seq_assemble #(.DW(DW)) u_asm (
    .clk(clk), .rst_n(rst_n), .cap_word(cap_word), .cap_lo(cap_lo),
    .cap_hi(cap_hi), .bus(adc_data), .res_data(res_data), .res_valid(res_valid)
  );

  AST_RC_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rc |-> !adc_cs_n);                                          // R2
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_busy) |-> (adc_cs_n || adc_rc));                       // R3
  AST_TMO_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> (adc_cs_n && adc_rc && req_ready && !res_valid));    // R4
  AST_SAMPLE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    sample_fire |-> (!adc_cs_n && adc_rc));                          // R5
  AST_WORD_BYTE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cap_word |-> !adc_byte);                                         // R6
  AST_HI_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hi |-> adc_byte);                                            // R7
  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> adc_cs_n);                                         // R9
endmodule

// File: tb/sim_adc_rd_seq.sv
module sim_adc_rd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, byte_mode = 1'b0;
  logic [CW-1:0] cvt_clks = '0, acc_clks = '0, tmo_clks = '0;
  logic req_ready, adc_cs_n, adc_rc, adc_byte, res_valid, tmo_err;
  logic adc_busy;
  logic [DW-1:0] adc_data, res_data;

  int total = 0, bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_rd_seq #(.DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .byte_mode(byte_mode),
    .cvt_clks(cvt_clks), .acc_clks(acc_clks), .tmo_clks(tmo_clks),
    .req_ready(req_ready), .adc_cs_n(adc_cs_n), .adc_rc(adc_rc),
    .adc_byte(adc_byte), .adc_busy(adc_busy), .adc_data(adc_data),
    .res_data(res_data), .res_valid(res_valid), .tmo_err(tmo_err)
  );

  // ---------------- converter model ----------------
  int          m_k = 1;       // busy low length in clocks
  int          m_d = 0;       // access clocks before data is good
  logic [15:0] m_word = '0;
  int          kcnt = 0, age = 0, starts = 0, viols = 0;
  logic        or_prev = 1'b1;
  logic [1:0]  key_prev = 2'b00;
  logic        m_busy = 1'b1;
  wire         en = !adc_cs_n && adc_rc;
  wire  [1:0]  key = {en, adc_byte};

  assign adc_busy = m_busy;
  assign adc_data = (en && age >= m_d) ?
                    (adc_byte ? {m_word[7:0], m_word[15:8]} : m_word) : 16'h5A5A;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b1; or_prev <= 1'b1; age <= 0; key_prev <= 2'b00; kcnt <= 0;
    end else begin
      or_prev  <= adc_cs_n | adc_rc;
      key_prev <= key;
      if (en && key == key_prev) age <= age + 1;
      else                       age <= en ? 1 : 0;
      if (!(adc_cs_n | adc_rc) && or_prev) begin
        starts <= starts + 1;
        m_busy <= 1'b0;
        kcnt   <= m_k;
      end else if (!m_busy) begin
        if (kcnt <= 1) begin
          m_busy <= 1'b1;
          if (!(adc_cs_n | adc_rc)) viols <= viols + 1;
        end else kcnt <= kcnt - 1;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int eff1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // busy rises in wait cycle k+1-n; window covers cycles 0..t-1
  function automatic bit want_err(input int n, input int k, input int t);
    return (k + 2 - eff1(n)) > eff1(t);
  endfunction

  task automatic run_txn(input bit mode, input int n, input int k, input int t,
                         input int a, input logic [15:0] w);
    int rc_lo, nval, nerr, post, s0;
    logic [15:0] got;
    bit e;
    rc_lo = 0; nval = 0; nerr = 0; post = 0; got = '0;
    e = want_err(n, k, t);
    @(negedge clk);
    m_k = k; m_d = a; m_word = w;
    byte_mode = mode; cvt_clks = CW'(n); acc_clks = CW'(a); tmo_clks = CW'(t);
    s0 = starts;
    chk(req_ready == 1'b1, "R9 ready in idle", int'(req_ready), 1);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int c = 0; c < 600; c++) begin
      if (!adc_rc) rc_lo++;
      if (res_valid) begin nval++; got = res_data; end
      if (tmo_err) nerr++;
      if (c == 1) begin
        chk(req_ready == 1'b0 && adc_cs_n == (adc_rc ? 1'b1 : 1'b0) || req_ready == 1'b0,
            "R9 busy not ready", int'(req_ready), 0);
        req = 1'b1;                       // must be ignored
      end else req = 1'b0;
      if (nval + nerr > 0) post++;
      if (post >= 4 && m_busy && req_ready) break;
      @(negedge clk);
    end
    chk(rc_lo == eff1(n), "R2 strobe low width", rc_lo, eff1(n));
    chk(starts - s0 == 1, "R3 R9 one start per request", starts - s0, 1);
    chk(adc_cs_n == 1'b1, "R9 deselect after txn", int'(adc_cs_n), 1);
    if (e) begin
      chk(nerr == 1, "R4 timeout pulse", nerr, 1);
      chk(nval == 0, "R4 no result on timeout", nval, 0);
    end else begin
      chk(nerr == 0, "R4 no timeout", nerr, 0);
      chk(nval == 1, "R8 single valid", nval, 1);
      if (mode) chk(got == w, "R7 R5 byte-mode result", int'(got), int'(w));
      else      chk(got == w, "R6 R5 word-mode result", int'(got), int'(w));
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, k, t, a;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1 reset cs_n", int'(adc_cs_n), 1);
    chk(adc_rc == 1'b1, "R1 reset rc", int'(adc_rc), 1);
    chk(adc_byte == 1'b0, "R1 reset byte", int'(adc_byte), 0);
    chk(res_valid == 1'b0 && tmo_err == 1'b0, "R1 reset pulses", int'({res_valid, tmo_err}), 0);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners
    run_txn(1'b0, 0, 1, 10, 0, 16'h1234);   // R2 zero strobe setting
    run_txn(1'b1, 1, 1, 10, 0, 16'hFF00);   // R7 byte order
    run_txn(1'b1, 2, 3, 10, 3, 16'h00FF);   // R7 R5 access wait
    run_txn(1'b0, 2, 5, 5, 2, 16'hBEEF);    // R4 window exactly met
    run_txn(1'b0, 2, 5, 4, 2, 16'hCAFE);    // R4 window one short
    run_txn(1'b1, 1, 20, 0, 1, 16'h8001);   // R4 zero window

    for (int i = 0; i < 80; i++) begin
      n = 1 + int'($urandom % 4);
      k = n + int'($urandom % 6);
      a = int'($urandom % 4);
      t = k + 2 - n + int'($urandom % 3) - ((i % 5 == 0) ? 1 : 0);
      run_txn(1'($urandom % 2), n, k, t, a, 16'($urandom));
    end

    chk(viols == 0, "R3 busy rose while strobe and select low", viols, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule